// File: doc/BRIEF.md
# Masked Alarm Interrupt Unit

This unit raises a time-of-day alarm for a real-time clock. Once per second it compares the running seconds, minutes, hours and day-of-month values against four programmable alarm registers. The top bit of each alarm register is a mask bit, and the four mask bits together choose how often the alarm repeats. When a qualified match happens, the unit sets an alarm flag. It then pulls an active-low, open-drain-style interrupt line low, provided the enable bits allow it. The clock counters live elsewhere, so the current time arrives on input ports together with a one-second tick.

A processor programs the unit through a small byte-wide register bus. The bus is gated by a select line and carries a 4-bit register address. Any read or write of the flags register (address 0h) releases the interrupt at once. The flag itself is cleared only when that access ends. A main-power input separates normal operation from battery backup. In backup the bus is ignored, and an interrupt needs a second enable bit. When main power returns, both enables are cleared. The same pin can also carry a frequency-test square wave, which toggles on every strobe of an external 1024 Hz reference and so gives 512 Hz.

Two state machines control the behaviour:
- The power machine has the states PWR_BACKUP and PWR_MAIN. It moves from backup to main when main power is present, which is the power-up transition that clears the enables. It moves from main to backup when main power is lost.
- The access machine has the states ACC_IDLE and ACC_FLAGS. It moves from idle to flags when a flags-register access is seen. It moves from flags back to idle when that access ends, and that transition issues the flag clear.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset the alarm flag is 0, the interrupt output enable `irq_oe` is 0, and both interrupt enables are 0.
- R2: The alarm registers sit at addresses 2h (seconds), 3h (minutes), 4h (hours) and 5h (date). Bit 7 of each is its mask bit, bits 6:0 are compared for seconds and minutes, and bits 5:0 for hours and date. With the mask bits {date,hour,min,sec} the modes are: 1111 fires every tick; 1110 needs a seconds match; 1100 needs seconds and minutes; 1000 needs seconds, minutes and hours; 0000 needs all four.
- R3: Any other mask pattern behaves like 1111 and fires on every tick.
- R4: Matching is evaluated only on a cycle with `sec_tick` high, and a hit sets `alarm_flag` on the following cycle. On main power, `irq_oe` is 1 while the flag is set and AE (bit 7 of register 6h) is 1. With AE at 0 the flag still sets but `irq_oe` stays 0.
- R5: With `main_pwr` low, `irq_oe` follows the alarm only when both AE and ABE (bit 6 of register 6h) are 1. In this mode every bus write and every flags access is ignored.
- R6: The first cycle with `main_pwr` high after backup clears AE and ABE. A tick hit in that same cycle still sets the flag.
- R7: A read or write of address 0h while `bus_sel` is high releases `irq_oe` in the same cycle. The output stays released for the one cycle after the access ends, and the flag clears at the end of that cycle. A tick hit on that clearing edge wins, and the flag stays 1.
- R8: When `osc_run` and `ft_bit` are 1, AE is 0, and `wdog_steer` or `wdog_zero` is 1, `irq_oe` is a square wave that toggles on each cycle following a `ft_strobe` pulse. Otherwise the frequency-test phase is held at 0.
- R9: A register is written only on a cycle with `bus_sel` and `bus_wr` both high. Writes to addresses other than 2h to 6h do not change any enable or alarm setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_pwr | input | 1 | 1 on main power, 0 in battery backup |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, 24-hour |
| cur_date | input | 8 | Current day of month, BCD |
| bus_sel | input | 1 | Register select, active high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| osc_run | input | 1 | Oscillator running |
| ft_bit | input | 1 | Frequency-test request bit |
| wdog_steer | input | 1 | Watchdog steering bit |
| wdog_zero | input | 1 | Watchdog register holds 00h |
| ft_strobe | input | 1 | 1024 Hz reference pulse |
| alarm_flag | output | 1 | Alarm flag |
| irq_oe | output | 1 | 1 pulls the interrupt pin low; 0 leaves it high-impedance |

## Verification
Two events can land on the same clock edge: the end of a flags-register access and a one-second tick that matches the alarm. That edge would both clear and set the flag. The bench provokes it by dropping the access strobe in the same cycle that it raises a matching tick. It expects the flag to stay set and the interrupt to reappear once the trailing release cycle is over. The bench also lets a power-up edge coincide with a matching tick. It expects the flag to be set while the enables read back as cleared. A behavioural model compares the flag and the pin on every cycle.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int NUM_FIELDS   = 4;
    localparam int MASK_BIT     = 7;
    localparam int REG_FLAGS    = 0;
    localparam int REG_ALM_BASE = 2;
    localparam int REG_INTEN    = 6;
    localparam int INTEN_AE     = 7;
    localparam int INTEN_ABE    = 6;

    typedef enum logic {
        PWR_BACKUP,
        PWR_MAIN
    } pwr_state_t;

    typedef enum logic {
        ACC_IDLE,
        ACC_FLAGS
    } acc_state_t;

    typedef enum logic [2:0] {
        RATE_EVERY,
        RATE_SEC,
        RATE_MIN,
        RATE_HOUR,
        RATE_DATE
    } rate_t;

    typedef enum logic {
        OUT_ALARM,
        OUT_FREQ
    } out_mode_t;

    // compared bits per field: seconds/minutes use 7, hours/date use 6
    function automatic int field_width(int idx);
        return (idx < 2) ? 7 : 6;
    endfunction

    // mask order {date, hour, min, sec}
    function automatic rate_t decode_rate(logic [NUM_FIELDS-1:0] m);
        rate_t r;
        unique case (m)
            4'b1111: r = RATE_EVERY;
            4'b1110: r = RATE_SEC;
            4'b1100: r = RATE_MIN;
            4'b1000: r = RATE_HOUR;
            4'b0000: r = RATE_DATE;
            default: r = RATE_EVERY;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_irq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [NUM_FIELDS-1:0][DW-1:0] cur_vec,
    input  logic [NUM_FIELDS-1:0][DW-1:0] alm_vec,
    output logic                          hit
);

    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] mask;
    rate_t                 rate;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam int FW = field_width(i);
        assign eq[i]   = (cur_vec[i][FW-1:0] == alm_vec[i][FW-1:0]);
        assign mask[i] = alm_vec[i][MASK_BIT];
    end

    assign rate = decode_rate(mask);

    always_comb begin
        unique case (rate)
            RATE_EVERY: hit = 1'b1;
            RATE_SEC:   hit = eq[0];
            RATE_MIN:   hit = eq[0] & eq[1];
            RATE_HOUR:  hit = &eq[2:0];
            RATE_DATE:  hit = &eq;
            default:    hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic main_pwr,
    output logic bus_ok,
    output logic pwr_up
);

    pwr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_BACKUP: if (main_pwr)  state_d = PWR_MAIN;
            PWR_MAIN:   if (!main_pwr) state_d = PWR_BACKUP;
            default:    state_d = PWR_BACKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_BACKUP;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_ok = 1'b0;
        pwr_up = 1'b0;
        unique case (state_q)
            PWR_BACKUP: pwr_up = main_pwr;
            PWR_MAIN:   bus_ok = main_pwr;
            default:    ;
        endcase
    end

    // R5: no bus traffic is accepted without main power
    assert_bus_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr |-> !bus_ok);

endmodule

// File: rtl/acc_fsm.sv
module acc_fsm
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req,
    output logic hold,
    output logic clr
);

    acc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  if (acc_req)  state_d = ACC_FLAGS;
            ACC_FLAGS: if (!acc_req) state_d = ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        hold = 1'b0;
        clr  = 1'b0;
        unique case (state_q)
            ACC_IDLE:  ;
            ACC_FLAGS: begin
                hold = 1'b1;
                clr  = !acc_req;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/irq_drive.sv
module irq_drive
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_run,
    input  logic ft_bit,
    input  logic ae,
    input  logic wdog_steer,
    input  logic wdog_zero,
    input  logic ft_strobe,
    input  logic alarm_req,
    output logic irq_oe
);

    out_mode_t mode;
    logic      ft_phase;

    always_comb begin
        if (osc_run && ft_bit && !ae && (wdog_steer || wdog_zero)) mode = OUT_FREQ;
        else                                                        mode = OUT_ALARM;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               ft_phase <= 1'b0;
        else if (mode != OUT_FREQ) ft_phase <= 1'b0;
        else if (ft_strobe)        ft_phase <= ~ft_phase;
    end

    always_comb begin
        unique case (mode)
            OUT_FREQ:  irq_oe = ft_phase;
            OUT_ALARM: irq_oe = alarm_req;
            default:   irq_oe = 1'b0;
        endcase
    end

    // R8: a strobe in test mode flips the pin on the next cycle
    assert_ft_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode == OUT_FREQ && $past(mode == OUT_FREQ) && $past(ft_strobe))
        |-> (irq_oe != $past(irq_oe)));

endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_irq_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          main_pwr,
    input  logic          sec_tick,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_date,
    input  logic          bus_sel,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          osc_run,
    input  logic          ft_bit,
    input  logic          wdog_steer,
    input  logic          wdog_zero,
    input  logic          ft_strobe,
    output logic          alarm_flag,
    output logic          irq_oe
);

    logic [NUM_FIELDS-1:0][DW-1:0] cur_vec;
    logic [NUM_FIELDS-1:0][DW-1:0] alm_q;
    logic bus_ok, pwr_up, hold, clr, hit, tick_hit;
    logic acc_flags, wr_en, ae_q, abe_q, af_q, alarm_req;

    assign cur_vec   = {cur_date, cur_hour, cur_min, cur_sec};
    assign acc_flags = bus_ok && bus_sel && (bus_rd || bus_wr) && (bus_addr == AW'(REG_FLAGS));
    assign wr_en     = bus_ok && bus_sel && bus_wr;
    assign tick_hit  = sec_tick && hit;

    pwr_fsm u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .main_pwr (main_pwr),
        .bus_ok   (bus_ok),
        .pwr_up   (pwr_up)
    );

    acc_fsm u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_req (acc_flags),
        .hold    (hold),
        .clr     (clr)
    );

    alarm_cmp #(.DW(DW)) u_cmp (
        .cur_vec (cur_vec),
        .alm_vec (alm_q),
        .hit     (hit)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alm
        always_ff @(posedge clk) begin
            if (!rst_n)
                alm_q[i] <= '0;
            else if (wr_en && bus_addr == AW'(REG_ALM_BASE + i))
                alm_q[i] <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || pwr_up) begin
            ae_q  <= 1'b0;
            abe_q <= 1'b0;
        end else if (wr_en && bus_addr == AW'(REG_INTEN)) begin
            ae_q  <= bus_wdata[INTEN_AE];
            abe_q <= bus_wdata[INTEN_ABE];
        end
    end

    // a fresh hit outranks the clear at the end of a flags access
    always_ff @(posedge clk) begin
        if (!rst_n)        af_q <= 1'b0;
        else if (tick_hit) af_q <= 1'b1;
        else if (clr)      af_q <= 1'b0;
    end

    assign alarm_req  = af_q && ae_q && (main_pwr || abe_q) && !(acc_flags || hold);
    assign alarm_flag = af_q;

    irq_drive u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_run    (osc_run),
        .ft_bit     (ft_bit),
        .ae         (ae_q),
        .wdog_steer (wdog_steer),
        .wdog_zero  (wdog_zero),
        .ft_strobe  (ft_strobe),
        .alarm_req  (alarm_req),
        .irq_oe     (irq_oe)
    );

    // R4: the flag only rises after a tick
    assert_af_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(af_q)) |-> $past(sec_tick));

    // R7: a flags access releases the pin while enabled
    assert_release_on_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_flags && ae_q) |-> !irq_oe);

    // R7: the flag falls only at the end of a flags access
    assert_clear_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(af_q)) |-> ($past(hold) && !$past(acc_flags)));

    // R6: power return wipes both enables
    assert_powerup_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && main_pwr && !$past(main_pwr)) |=> (!ae_q && !abe_q));

    // R5: backup without the second enable keeps the pin released
    assert_backup_needs_abe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_pwr && ae_q && !abe_q) |-> !irq_oe);

endmodule

// File: tb/alarm_irq_unit_test.sv
module alarm_irq_unit_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_pwr = 1'b1;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00, cur_date = 8'h01;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic       osc_run = 1'b0, ft_bit = 1'b0, wdog_steer = 1'b0, wdog_zero = 1'b0, ft_strobe = 1'b0;
    logic       alarm_flag, irq_oe;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // behavioural reference state
    bit       m_af, m_ae, m_abe, m_main, m_hold, m_ph;
    bit [7:0] m_alm [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .main_pwr(main_pwr), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .osc_run(osc_run), .ft_bit(ft_bit), .wdog_steer(wdog_steer),
        .wdog_zero(wdog_zero), .ft_strobe(ft_strobe), .alarm_flag(alarm_flag), .irq_oe(irq_oe)
    );

    function automatic bit m_hit();
        bit [3:0] mk;
        bit s, mi, h, d;
        mk = {m_alm[3][7], m_alm[2][7], m_alm[1][7], m_alm[0][7]};
        s  = (cur_sec[6:0]  == m_alm[0][6:0]);
        mi = (cur_min[6:0]  == m_alm[1][6:0]);
        h  = (cur_hour[5:0] == m_alm[2][5:0]);
        d  = (cur_date[5:0] == m_alm[3][5:0]);
        if (mk == 4'b1110) return s;
        if (mk == 4'b1100) return s && mi;
        if (mk == 4'b1000) return s && mi && h;
        if (mk == 4'b0000) return s && mi && h && d;
        return 1'b1;
    endfunction

    function automatic bit m_ftm();
        return osc_run && ft_bit && !m_ae && (wdog_steer || wdog_zero);
    endfunction

    function automatic bit m_acc();
        return m_main && main_pwr && bus_sel && (bus_rd || bus_wr) && bus_addr == 4'h0;
    endfunction

    function automatic bit m_irq();
        if (m_ftm()) return m_ph;
        return m_af && m_ae && (main_pwr || m_abe) && !(m_acc() || m_hold);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_af = 0; m_ae = 0; m_abe = 0; m_main = 0; m_hold = 0; m_ph = 0;
            for (int i = 0; i < 4; i++) m_alm[i] = 8'h00;
        end else begin
            bit hitv, acc, ok, ftm;
            hitv = sec_tick && m_hit();
            acc  = m_acc();
            ok   = m_main && main_pwr;
            ftm  = m_ftm();
            if (hitv) m_af = 1;
            else if (m_hold && !acc) m_af = 0;
            m_hold = acc;
            if (ok && bus_sel && bus_wr) begin
                if (bus_addr >= 4'h2 && bus_addr <= 4'h5) m_alm[bus_addr - 4'h2] = bus_wdata;
                if (bus_addr == 4'h6) begin m_ae = bus_wdata[7]; m_abe = bus_wdata[6]; end
            end
            if (!ftm) m_ph = 0;
            else if (ft_strobe) m_ph = !m_ph;
            if (!m_main && main_pwr) begin m_main = 1; m_ae = 0; m_abe = 0; end
            else if (m_main && !main_pwr) m_main = 0;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (alarm_flag !== m_af || irq_oe !== m_irq()) begin
                errors++;
                $display("FAIL %s model: af=%0b irq=%0b expected af=%0b irq=%0b at %0t",
                         phase, alarm_flag, irq_oe, m_af, m_irq(), $time);
            end
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic expect_out(bit ea, bit ei, string tag);
        @(negedge clk);
        checks++;
        if (alarm_flag !== ea || irq_oe !== ei) begin
            errors++;
            $display("FAIL %s directed: af=%0b irq=%0b expected af=%0b irq=%0b", tag, alarm_flag, irq_oe, ea, ei);
        end
    endtask

    task automatic wr(bit [3:0] a, bit [7:0] d, bit sel = 1);
        bus_sel = sel; bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic tick();
        sec_tick = 1; cyc(); sec_tick = 0;
    endtask

    task automatic set_time(bit [7:0] s, bit [7:0] m, bit [7:0] h, bit [7:0] d);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
    endtask

    task automatic alarm_regs(bit [7:0] s, bit [7:0] m, bit [7:0] h, bit [7:0] d);
        wr(4'h2, s); wr(4'h3, m); wr(4'h4, h); wr(4'h5, d);
    endtask

    task automatic clear_flags();
        bus_sel = 1; bus_rd = 1; bus_addr = 4'h0;
        cyc(2);
        bus_sel = 0; bus_rd = 0;
        cyc(2);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired in phase %s", phase);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        phase = "R1";
        expect_out(0, 0, "R1 reset");
        cyc(2);

        phase = "R2";
        alarm_regs(8'h30, 8'h15, 8'h08, 8'h21);
        wr(4'h6, 8'h80);
        set_time(8'h30, 8'h15, 8'h08, 8'h22);
        tick();
        expect_out(0, 0, "R2 date mismatch in full mode");
        set_time(8'h30, 8'h15, 8'h08, 8'h21);
        tick();
        expect_out(1, 1, "R2 R4 full match raises irq");

        phase = "R7";
        bus_sel = 1; bus_rd = 1; bus_addr = 4'h0;
        expect_out(1, 0, "R7 released during access");
        cyc(2);
        bus_sel = 0; bus_rd = 0;
        expect_out(1, 0, "R7 trailing release cycle");
        cyc();
        expect_out(0, 0, "R7 flag cleared after access");

        phase = "R2";
        alarm_regs(8'h30, 8'h95, 8'h88, 8'hA1);
        set_time(8'h30, 8'h00, 8'h00, 8'h05);
        tick();
        expect_out(1, 1, "R2 seconds-only mode");
        clear_flags();
        alarm_regs(8'h30, 8'h15, 8'h88, 8'hA1);
        tick();
        expect_out(0, 0, "R2 minutes mismatch");
        set_time(8'h30, 8'h15, 8'h00, 8'h05);
        tick();
        expect_out(1, 1, "R2 minute mode hit");
        clear_flags();
        alarm_regs(8'h30, 8'h15, 8'h08, 8'hA1);
        tick();
        expect_out(0, 0, "R2 hours mismatch");
        set_time(8'h30, 8'h15, 8'h08, 8'h05);
        tick();
        expect_out(1, 1, "R2 hour mode hit");
        clear_flags();
        alarm_regs(8'hB0, 8'h95, 8'h88, 8'hA1);
        set_time(8'h11, 8'h22, 8'h03, 8'h09);
        tick();
        expect_out(1, 1, "R2 every-second mode");
        clear_flags();

        phase = "R3";
        alarm_regs(8'hB0, 8'h15, 8'h88, 8'h21);
        tick();
        expect_out(1, 1, "R3 unlisted mask fires");
        clear_flags();

        phase = "R4";
        sec_tick = 0;
        cyc(3);
        expect_out(0, 0, "R4 no tick no flag");
        wr(4'h6, 8'h00);
        tick();
        expect_out(1, 0, "R4 AE off keeps pin released");

        phase = "R9";
        wr(4'h6, 8'h80, 0);
        expect_out(1, 0, "R9 write without select ignored");
        wr(4'h7, 8'hFF);
        wr(4'h1, 8'hFF);
        expect_out(1, 0, "R9 other addresses ignored");
        wr(4'h6, 8'h80);
        expect_out(1, 1, "R9 selected write enables");

        phase = "R7";
        bus_sel = 1; bus_wr = 1; bus_addr = 4'h0;
        cyc(2);
        bus_sel = 0; bus_wr = 0; sec_tick = 1;
        cyc();
        sec_tick = 0;
        expect_out(1, 1, "R7 tick on clearing edge keeps flag");
        clear_flags();

        phase = "R5";
        wr(4'h6, 8'h80);
        main_pwr = 0;
        cyc();
        tick();
        expect_out(1, 0, "R5 backup without ABE");
        wr(4'h6, 8'hC0);
        expect_out(1, 0, "R5 backup write ignored");
        main_pwr = 1;
        cyc(2);
        clear_flags();
        wr(4'h6, 8'hC0);
        main_pwr = 0;
        cyc();
        tick();
        expect_out(1, 1, "R5 backup with AE and ABE");
        bus_sel = 1; bus_rd = 1; bus_addr = 4'h0;
        cyc(2);
        bus_sel = 0; bus_rd = 0;
        cyc();
        expect_out(1, 1, "R5 flags access ignored in backup");

        phase = "R6";
        main_pwr = 1;
        cyc();
        expect_out(1, 0, "R6 power-up clears enables");
        cyc();
        clear_flags();
        main_pwr = 0;
        cyc(2);
        main_pwr = 1; sec_tick = 1;
        cyc();
        sec_tick = 0;
        expect_out(1, 0, "R6 alarm during power-up sets flag");
        cyc();
        clear_flags();

        phase = "R8";
        wr(4'h6, 8'h00);
        osc_run = 1; ft_bit = 1; wdog_steer = 1;
        for (int k = 0; k < 6; k++) begin
            ft_strobe = 1; cyc(); ft_strobe = 0;
            expect_out(0, (k % 2) == 0, "R8 steer toggles");
            cyc(2);
        end
        wdog_steer = 0; wdog_zero = 0;
        ft_strobe = 1; cyc(); ft_strobe = 0;
        expect_out(0, 0, "R8 no watchdog condition");
        wdog_zero = 1;
        for (int k = 0; k < 4; k++) begin
            ft_strobe = 1; cyc(); ft_strobe = 0;
            expect_out(0, (k % 2) == 0, "R8 zero watchdog toggles");
        end
        wr(4'h6, 8'h80);
        ft_strobe = 1; cyc(); ft_strobe = 0;
        expect_out(0, 0, "R8 AE blocks test mode");
        cyc(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule